// File: doc/BRIEF.md
# Slave-Serial Configuration Sequencer

This block loads a configuration bit stream into a target device over a three-wire serial link: an active-low program line, a configuration clock and a data line. The target's init and done status lines come back into the block. A start pulse runs the whole load with no further help:

1. The block pulses the program line and waits for the target to clear.
2. It releases the program line and waits for the target to become ready.
3. It optionally shifts a fixed 16-bit sync header.
4. It shifts the caller's bits, which arrive one per valid/ready handshake.
5. It waits for the target to report completion.

Each of the three waits has its own timeout and its own error code. While the block runs, `busy_o` is high. When it finishes, it holds either `ok_o` or `err_o` with a code until the next start.

Every configuration bit takes four steps, and each step lasts `STEP_DIV` system clocks:

1. Clock low, data high.
2. Clock low, data set to the bit value.
3. Clock high, data unchanged.
4. Clock high, data driven back high.

So the target samples on the rising clock edge, and the data line is always high again when the clock falls. The block resynchronises the init and done inputs through two flops before it uses them. The timeout length `TMO_CYC` is given in system clocks, so it can be sized to a few milliseconds.

Top module: `sscfg_sequencer`

## Requirements
- R1: After reset, and whenever no load is running, `prog_n_o`, `cclk_o` and `cdata_o` are all 1, `busy_o` is 0, and after reset `ok_o` and `err_o` are 0 and `err_code_o` is 0.
- R2: When `start_i` is sampled high while idle, `prog_n_o` goes to 0 while clock and data stay 1, and the block waits for the synchronised init input to be 0. If init stays 1 for `TMO_CYC` cycles, the load ends with error code 1.
- R3: Once init reads 0, `prog_n_o` returns to 1 and the block waits for init to read 1. If init stays 0 for `TMO_CYC` cycles, the load ends with error code 2.
- R4: Each bit is sent as four steps of `STEP_DIV` cycles each: (clock 0, data 1), (clock 0, data = bit), (clock 1, data = bit), (clock 1, data 1). The clock is therefore low for exactly 2*`STEP_DIV` cycles per bit, and data is 1 whenever the clock falls.
- R5: If `hdr_en_i` is high when the load starts, the 16 bits 1,1,1,1,1,1,1,1,0,0,1,0,0,0,0,0 are sent first, in that order, before any stream bit.
- R6: Stream bits are accepted one at a time when `bit_valid_i` and `bit_ready_o` are both high, and are sent in the order accepted. The bit accepted with `bit_last_i` high is the final one. `bit_ready_o` is high only while no bit is being shifted.
- R7: After the final bit, the block waits for the synchronised done input to be 1. It then ends with `ok_o`=1 and code 0. If done stays 0 for `TMO_CYC` cycles, the load ends with error code 3.
- R8: `busy_o` is 1 from the cycle after start until the load ends. `ok_o` or `err_o` (never both) then holds until the next start, and `err_code_o` is non-zero exactly when `err_o` is 1.
- R9: `start_i` has no effect while `busy_o` is 1; the running load completes with its bit stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a load when idle or finished |
| hdr_en_i | input | 1 | Send the 16-bit sync header first (sampled at start) |
| bit_valid_i | input | 1 | Stream bit available |
| bit_data_i | input | 1 | Stream bit value |
| bit_last_i | input | 1 | Marks the final stream bit |
| bit_ready_o | output | 1 | Block can accept a stream bit |
| init_i | input | 1 | Target init status (asynchronous) |
| done_i | input | 1 | Target done status (asynchronous) |
| prog_n_o | output | 1 | Active-low program line to target |
| cclk_o | output | 1 | Configuration clock to target |
| cdata_o | output | 1 | Configuration data to target |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load succeeded |
| err_o | output | 1 | Last load failed |
| err_code_o | output | 2 | 1: init never fell, 2: init never rose, 3: done never rose |

## Verification
The hardest case to reach is the init-high timeout (code 2). It needs a target that answers the program pulse but then never leaves its clearing phase. The bench models the target as init following the program line through a short delay, with a fault mode that latches init low once it has fallen. A second fault mode holds init high throughout, and a third withholds done. The same model drives the error paths and the successful loads. A start pulse injected in the middle of a header shift shows that a running load ignores it.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG_LO,
    ST_PROG_HI,
    ST_HDR,
    ST_DATA,
    ST_WAIT_DONE,
    ST_OK,
    ST_FAIL
  } ld_state_e;

  localparam logic [1:0] CODE_NONE      = 2'd0;
  localparam logic [1:0] CODE_INIT_LOW  = 2'd1;
  localparam logic [1:0] CODE_INIT_HIGH = 2'd2;
  localparam logic [1:0] CODE_DONE      = 2'd3;

  localparam int          HDR_BITS = 16;
  localparam logic [15:0] HDR_WORD = 16'hFF20;

endpackage

// File: rtl/sscfg_sync.sv
module sscfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d_i;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[gi] <= '0;
      else        stg_q[gi] <= stg_q[gi-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sscfg_timer.sv
module sscfg_timer #(
  parameter int LIMIT = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired_o = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)           cnt_d = '0;
    else if (!expired_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2 R3 R7: the wait counter saturates at the limit and never passes it
  a_r7_tmo_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o && !clr_i |=> expired_o);
endmodule

// File: rtl/sscfg_bitphase.sv
module sscfg_bitphase #(
  parameter int STEP_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic bit_i,
  output logic busy_o,
  output logic cclk_o,
  output logic cdata_o
);
  localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  logic          act_q, act_d;
  logic [1:0]    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          bit_q, bit_d;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    if (!act_q) begin
      if (load_i) begin
        act_d = 1'b1;
        ph_d  = 2'd0;
        cnt_d = '0;
        bit_d = bit_i;
      end
    end else if (cnt_q == CW'(STEP_DIV - 1)) begin
      cnt_d = '0;
      if (ph_q == 2'd3) act_d = 1'b0;
      else              ph_d  = ph_q + 2'd1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 2'd0;
      cnt_q <= '0;
      bit_q <= 1'b1;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
    end
  end

  assign busy_o  = act_q;
  assign cclk_o  = !act_q || ph_q[1];
  assign cdata_o = !act_q || (ph_q == 2'd0) || (ph_q == 2'd3) || bit_q;

  // R4: data is high on the cycle before every falling clock
  a_r4_data_high_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk_o) |-> $past(cdata_o));
  // R4: while clock stays high, data may only change by returning high
  a_r4_data_only_rises_hi: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o && $past(cclk_o) && !$stable(cdata_o) |-> cdata_o);
endmodule

// File: rtl/sscfg_sequencer.sv
module sscfg_sequencer
  import sscfg_pkg::*;
#(
  parameter int STEP_DIV = 4,
  parameter int TMO_CYC  = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       hdr_en_i,
  input  logic       bit_valid_i,
  input  logic       bit_data_i,
  input  logic       bit_last_i,
  output logic       bit_ready_o,
  input  logic       init_i,
  input  logic       done_i,
  output logic       prog_n_o,
  output logic       cclk_o,
  output logic       cdata_o,
  output logic       busy_o,
  output logic       ok_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);
  localparam int HIW = $clog2(HDR_BITS + 1);

  ld_state_e      state_q, state_d;
  logic [HIW-1:0] hidx_q, hidx_d;
  logic           last_q, last_d;
  logic           hdr_q, hdr_d;
  logic [1:0]     code_q, code_d;
  logic           prog_n_q;
  logic           sh_load, sh_bit, sh_busy;
  logic           tmo;
  logic [1:0]     st_sync;
  logic           init_s, done_s;

  sscfg_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({done_i, init_i}), .q_o(st_sync)
  );
  assign init_s = st_sync[0];
  assign done_s = st_sync[1];

  sscfg_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(state_d != state_q), .expired_o(tmo)
  );

  sscfg_bitphase #(.STEP_DIV(STEP_DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .load_i(sh_load), .bit_i(sh_bit),
    .busy_o(sh_busy), .cclk_o(cclk_o), .cdata_o(cdata_o)
  );

  assign bit_ready_o = (state_q == ST_DATA) && !sh_busy && !last_q;

  always_comb begin
    state_d = state_q;
    hidx_d  = hidx_q;
    last_d  = last_q;
    hdr_d   = hdr_q;
    code_d  = code_q;
    sh_load = 1'b0;
    sh_bit  = 1'b1;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_FAIL: begin
        if (start_i) begin
          state_d = ST_PROG_LO;
          hidx_d  = '0;
          last_d  = 1'b0;
          hdr_d   = hdr_en_i;
          code_d  = CODE_NONE;
        end
      end
      ST_PROG_LO: begin
        if (!init_s) state_d = ST_PROG_HI;
        else if (tmo) begin
          state_d = ST_FAIL;
          code_d  = CODE_INIT_LOW;
        end
      end
      ST_PROG_HI: begin
        if (init_s) state_d = hdr_q ? ST_HDR : ST_DATA;
        else if (tmo) begin
          state_d = ST_FAIL;
          code_d  = CODE_INIT_HIGH;
        end
      end
      ST_HDR: begin
        if (!sh_busy) begin
          if (hidx_q == HIW'(HDR_BITS)) state_d = ST_DATA;
          else begin
            sh_load = 1'b1;
            sh_bit  = HDR_WORD[4'(HDR_BITS - 1) - hidx_q[3:0]];
            hidx_d  = hidx_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (last_q && !sh_busy) state_d = ST_WAIT_DONE;
        else if (bit_ready_o && bit_valid_i) begin
          sh_load = 1'b1;
          sh_bit  = bit_data_i;
          last_d  = bit_last_i;
        end
      end
      ST_WAIT_DONE: begin
        if (done_s) state_d = ST_OK;
        else if (tmo) begin
          state_d = ST_FAIL;
          code_d  = CODE_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      hidx_q   <= '0;
      last_q   <= 1'b0;
      hdr_q    <= 1'b0;
      code_q   <= CODE_NONE;
      prog_n_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      hidx_q   <= hidx_d;
      last_q   <= last_d;
      hdr_q    <= hdr_d;
      code_q   <= code_d;
      prog_n_q <= (state_d != ST_PROG_LO);
    end
  end

  assign prog_n_o   = prog_n_q;
  assign busy_o     = !(state_q inside {ST_IDLE, ST_OK, ST_FAIL});
  assign ok_o       = (state_q == ST_OK);
  assign err_o      = (state_q == ST_FAIL);
  assign err_code_o = code_q;

  // R1: pins rest high whenever no load is running
  a_r1_idle_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> prog_n_o && cclk_o && cdata_o);
  // R2: program line is low only during a running load
  a_r2_prog_low_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> busy_o && cclk_o && cdata_o);
  // R6: a stream bit is offered only while the shifter is quiet
  a_r6_ready_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready_o |-> cclk_o && cdata_o);
  // R8: outcome flags are exclusive and the code tracks the error flag
  a_r8_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && err_o) && (err_o == (err_code_o != CODE_NONE)));
  // R9: a start during a load leaves it running
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !tmo |=> busy_o || ok_o);
endmodule

// File: tb/tb_sscfg_sequencer.sv
module tb_sscfg_sequencer;
  localparam int DIV = 2;
  localparam int TMO = 200;
  localparam int NV  = 8;

  // {hdr_en, fault[1:0], nbits[4:0], pattern[15:0]}; fault 0 = healthy target,
  // 1 = init stuck high, 2 = init stuck low, 3 = done never rises
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 2'd0, 5'd16, 16'hA5C3},
    {1'b0, 2'd0, 5'd8,  16'h003C},
    {1'b0, 2'd0, 5'd1,  16'h0000},
    {1'b1, 2'd3, 5'd4,  16'h0009},
    {1'b0, 2'd1, 5'd0,  16'h0000},
    {1'b1, 2'd2, 5'd0,  16'h0000},
    {1'b0, 2'd0, 5'd16, 16'h0000},
    {1'b1, 2'd0, 5'd16, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, hdr_en_i = 1'b0;
  logic bit_valid_i = 1'b0, bit_data_i = 1'b0, bit_last_i = 1'b0;
  logic bit_ready_o, prog_n_o, cclk_o, cdata_o, busy_o, ok_o, err_o;
  logic [1:0] err_code_o;
  logic init_i = 1'b1;
  logic done_i = 1'b0;
  logic [1:0] fault = 2'd0;
  logic [3:0] pdly = 4'hF;

  int checks = 0, errors = 0;
  logic cap [512];
  int cap_tot = 0;
  int low_len = 0;
  int tim_bad = 0;

  always #4 clk = ~clk;

  sscfg_sequencer #(.STEP_DIV(DIV), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hdr_en_i(hdr_en_i),
    .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i), .bit_last_i(bit_last_i),
    .bit_ready_o(bit_ready_o), .init_i(init_i), .done_i(done_i),
    .prog_n_o(prog_n_o), .cclk_o(cclk_o), .cdata_o(cdata_o), .busy_o(busy_o),
    .ok_o(ok_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  // target model: init follows the program line four cycles late
  always @(posedge clk) begin
    pdly <= {pdly[2:0], prog_n_o};
    case (fault)
      2'd1:    init_i <= 1'b1;
      2'd2:    init_i <= init_i & pdly[3];
      default: init_i <= pdly[3];
    endcase
  end

  // capture what the target samples on each rising configuration clock
  always @(posedge cclk_o) begin
    if (cap_tot < 512) cap[cap_tot] = cdata_o;
    cap_tot = cap_tot + 1;
  end

  // R4 timing monitor: low time per bit and data level at each clock fall
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cclk_o) low_len = low_len + 1;
      else begin
        if (low_len != 0 && low_len != 2 * DIV) tim_bad = tim_bad + 1;
        low_len = 0;
      end
    end
  end
  always @(negedge cclk_o) if (!cdata_o) tim_bad = tim_bad + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic feed(input int nbits, input logic [15:0] pat);
    for (int i = nbits - 1; i >= 0; i--) begin
      bit_valid_i = 1'b1;
      bit_data_i  = pat[i];
      bit_last_i  = (i == 0);
      while (!bit_ready_o) @(negedge clk);
      @(negedge clk);
    end
    bit_valid_i = 1'b0;
    bit_last_i  = 1'b0;
  endtask

  task automatic run_vec(input logic hdr, input logic [1:0] flt,
                         input int nbits, input logic [15:0] pat, input bit poke);
    int base, tb0, cyc, n;
    logic exp_bits [32];
    @(negedge clk);
    fault    = flt;
    done_i   = 1'b0;
    hdr_en_i = hdr;
    base     = cap_tot;
    tb0      = tim_bad;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    chk(busy_o === 1'b1, "R8 busy after start", busy_o, 1);
    if (flt == 2'd1) begin
      repeat (3) @(negedge clk);
      chk(prog_n_o === 1'b0 && cclk_o && cdata_o, "R2 program low, clk/data high",
          {prog_n_o, cclk_o, cdata_o}, 3'b011);
    end
    cyc = 0;
    fork
      begin
        if (nbits > 0) feed(nbits, pat);
        if (flt == 2'd0) begin
          repeat (20) @(negedge clk);
          done_i = 1'b1;
        end
      end
      begin
        if (poke) begin
          repeat (30) @(negedge clk);
          chk(busy_o === 1'b1, "R9 load running at stray start", busy_o, 1);
          start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
        end
      end
    join
    while (busy_o) begin
      @(negedge clk);
      cyc++;
    end
    if (flt == 2'd1)
      chk(cyc >= TMO - 4 && cyc <= TMO + 2, "R2 init-low timeout length", cyc, TMO);
    chk(ok_o === (flt == 2'd0) && err_o === (flt != 2'd0),
        "R8 outcome flags", {ok_o, err_o}, {flt == 2'd0, flt != 2'd0});
    chk(err_code_o === flt, (flt == 2'd1) ? "R2 code" : (flt == 2'd2) ? "R3 code" :
        "R7 code", err_code_o, flt);
    chk(prog_n_o && cclk_o && cdata_o && !bit_ready_o, "R1 pins high after load",
        {prog_n_o, cclk_o, cdata_o}, 3'b111);
    n = 0;
    if (flt == 2'd0 || flt == 2'd3) begin
      if (hdr) for (int k = 15; k >= 0; k--) begin exp_bits[n] = 16'hFF20 >> k; n++; end
      for (int k = nbits - 1; k >= 0; k--) begin exp_bits[n] = pat[k]; n++; end
    end
    chk(cap_tot - base == n, hdr ? "R5 bit count with header" : "R6 bit count",
        cap_tot - base, n);
    for (int k = 0; k < n && k < cap_tot - base; k++)
      if (cap[base + k] !== exp_bits[k]) begin
        chk(1'b0, (hdr && k < 16) ? "R5 header bit" : "R6 stream bit", cap[base + k],
            exp_bits[k]);
        break;
      end
    chk(tim_bad == tb0, "R4 four-step phasing", tim_bad - tb0, 0);
    @(negedge clk);
    chk(ok_o === (flt == 2'd0) && err_o === (flt != 2'd0), "R8 outcome held",
        {ok_o, err_o}, {flt == 2'd0, flt != 2'd0});
    fault  = 2'd0;
    done_i = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !ok_o && !err_o && err_code_o == 0, "R1 reset status",
        {busy_o, ok_o, err_o}, 0);
    chk(prog_n_o && cclk_o && cdata_o, "R1 reset pins", {prog_n_o, cclk_o, cdata_o}, 3'b111);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy_o && prog_n_o && cclk_o && cdata_o, "R1 idle after reset",
        {busy_o, prog_n_o}, 2'b01);
    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][23], VEC[v][22:21], int'(VEC[v][20:16]), VEC[v][15:0], 1'b0);
    // R9: stray start while the header is shifting
    run_vec(1'b1, 2'd0, 6, 16'h002D, 1'b1);
    // R3: restart after an init-high failure clears the code and succeeds
    run_vec(1'b0, 2'd2, 0, 16'h0000, 1'b0);
    run_vec(1'b0, 2'd0, 3, 16'h0005, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule